// File: doc/BRIEF.md
# Serial-Programmed Output Pin Controller

This block takes configuration words over a three-wire serial link (serial clock, serial data, active-low enable) and keeps three control registers: an 8-bit port register, a 16-bit divider register and a 24-bit mode register. All three are held for the rest of the chip on configuration outputs. The length of each frame picks which register receives it. The link pins are sampled by the block's own system clock, so the whole design runs in a single clock domain. The edges of the serial clock and the enable are found by comparing each pin with its value one cycle earlier.

The two top bits of the mode register steer the multiplexed pin `out_a`. It can show one of four things:
- the reference-divider pulse,
- the feedback-divider pulse,
- a serial cascade stream that lets several devices be chained on one link,
- a plain port bit taken from the port register.

The cascade stream comes from an extra half stage that follows the top bit of the shift register and moves only when the serial clock falls. At power-on the cascade stream is the selected source.

The second pin is an open-drain port. It is modelled as a constant low output value plus an output enable, which is forced on during reset.

Top module: `outpin_ctrl`

## Requirements
- R1: While `ser_en_n` is low, each rising edge of `ser_clk` shifts `ser_dat` into the shift register's least significant bit. Frames are therefore sent most significant bit first, and the last bit sent lands in bit 0 of the target register.
- R2: When `ser_en_n` rises after exactly 8 serial clocks, `cfg_c` takes the shifted word. Bit 0 of `cfg_c` is the open-drain control and bit 1 is the port bit.
- R3: When `ser_en_n` rises after exactly 16 serial clocks, `cfg_r` takes the shifted word.
- R4: When `ser_en_n` rises after exactly 24 serial clocks, `cfg_a` takes the shifted word. Bits 23:22 of `cfg_a` are the output select.
- R5: A frame of any other length changes none of the registers. No register changes except on a rising edge of `ser_en_n`.
- R6: `out_a` follows the select in `cfg_a[23:22]`:
  - 11 selects `ref_pulse`.
  - 10 selects `fb_pulse`.
  - 01 selects the serial cascade output.
  - 00 selects `cfg_c[1]`, so the pin is low when that bit is 0 and high when it is 1.
- R7: The cascade output takes the value of shift register bit 23 only on a falling edge of `ser_clk`. It holds across rising edges.
- R8: `out_b_val` is always 0. `out_b_oe` is 1 (pin driven low) when `cfg_c[0]` is 0, and 0 (high impedance) when `cfg_c[0]` is 1.
- R9: Reset sets the following values:
  - `cfg_a` = 24'h400000, so the cascade output is selected.
  - `cfg_c` = 0, so `out_b_oe` = 1.
  - `cfg_r` = 0.
  - The shift register and the cascade output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial link |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_clk | input | 1 | Serial clock, synchronous to clk |
| ser_dat | input | 1 | Serial data, taken on rising ser_clk |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge latches the frame |
| ref_pulse | input | 1 | Reference-divider output pulse |
| fb_pulse | input | 1 | Feedback-divider output pulse |
| out_a | output | 1 | Multiplexed digital output |
| out_b_val | output | 1 | Open-drain pin value, constant 0 |
| out_b_oe | output | 1 | Open-drain pin enable, 1 means driven low |
| cfg_c | output | 8 | Port register contents |
| cfg_r | output | 16 | Divider register contents |
| cfg_a | output | 24 | Mode register contents |

## Verification
The bound checker watches several properties on every cycle:
- The cascade output moves only after a falling serial clock.
- No register changes unless the enable has just risen.
- The open-drain enable moves only when the port register does.
- The cascade source passes unchanged to `out_a` while it is selected.
- Reset holds the power-on values.

Other behaviour only the bench's scenarios can show:
- Which register a frame of a given length reaches.
- The bit order.
- That a 12-bit or 26-bit frame is dropped.
- That each of the four select codes routes the right source, checked with distinct input patterns.

// File: rtl/outpin_pkg.sv
package outpin_pkg;

    // Default register widths.
    localparam int PORT_REG_W = 8;
    localparam int DIV_REG_W  = 16;
    localparam int MODE_REG_W = 24;

    // Power-on value of the mode register: cascade output selected.
    localparam logic [MODE_REG_W-1:0] MODE_RST = 24'h400000;

    // Output A source codes, held in the top two bits of the mode register.
    typedef enum logic [1:0] {
        OSEL_PORT = 2'b00,
        OSEL_CASC = 2'b01,
        OSEL_FB   = 2'b10,
        OSEL_REF  = 2'b11
    } osel_e;

    // Bit positions inside the port register.
    localparam int OUTB_BIT = 0;
    localparam int PORT_BIT = 1;

endpackage

// File: rtl/ser_edge.sv
module ser_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_en_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic en_rise,
    output logic frame_open
);

    typedef struct packed {
        logic sclk;
        logic en_n;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = ser_clk;
        st_d.en_n = ser_en_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sclk: 1'b0, en_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_rise  =  ser_clk  & ~st_q.sclk;
    assign sclk_fall  = ~ser_clk  &  st_q.sclk;
    assign en_rise    =  ser_en_n & ~st_q.en_n;
    assign frame_open = ~ser_en_n;

endmodule

// File: rtl/shift_path.sv
module shift_path #(
    parameter int SH_W  = 24,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             frame_open,
    input  logic             ser_dat,
    output logic [SH_W-1:0]  shift_word,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             casc_out
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [SH_W-1:0]  word;
        logic [CNT_W-1:0] cnt;
        logic             half;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Count only inside an open frame; saturate so long frames stay invalid.
        if (!frame_open) begin
            st_d.cnt = '0;
        end else if (sclk_rise) begin
            st_d.word = {st_q.word[SH_W-2:0], ser_dat};
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        // Half stage: the cascade bit moves on the falling serial clock only.
        if (sclk_fall) begin
            st_d.half = st_q.word[SH_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_word = st_q.word;
    assign bit_cnt    = st_q.cnt;
    assign casc_out   = st_q.half;

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
    parameter int              C_W   = 8,
    parameter int              R_W   = 16,
    parameter int              A_W   = 24,
    parameter int              CNT_W = 5,
    parameter logic [A_W-1:0]  A_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic [A_W-1:0]   shift_word,
    output logic [C_W-1:0]   cfg_c,
    output logic [R_W-1:0]   cfg_r,
    output logic [A_W-1:0]   cfg_a
);

    localparam logic [CNT_W-1:0] LEN_C = CNT_W'(C_W);
    localparam logic [CNT_W-1:0] LEN_R = CNT_W'(R_W);
    localparam logic [CNT_W-1:0] LEN_A = CNT_W'(A_W);

    typedef struct packed {
        logic [C_W-1:0] c;
        logic [R_W-1:0] r;
        logic [A_W-1:0] a;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_stb) begin
            // Frame length picks the destination; other lengths fall through.
            if (bit_cnt == LEN_C) begin
                st_d.c = shift_word[C_W-1:0];
            end else if (bit_cnt == LEN_R) begin
                st_d.r = shift_word[R_W-1:0];
            end else if (bit_cnt == LEN_A) begin
                st_d.a = shift_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{c: '0, r: '0, a: A_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_c = st_q.c;
    assign cfg_r = st_q.r;
    assign cfg_a = st_q.a;

endmodule

// File: rtl/outa_mux.sv
module outa_mux
    import outpin_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       ref_pulse,
    input  logic       fb_pulse,
    input  logic       casc_out,
    input  logic       port_bit,
    output logic       out_a
);

    osel_e sel_e;

    always_comb begin
        sel_e = osel_e'(sel);
        unique case (sel_e)
            OSEL_REF:  out_a = ref_pulse;
            OSEL_FB:   out_a = fb_pulse;
            OSEL_CASC: out_a = casc_out;
            OSEL_PORT: out_a = port_bit;
            default:   out_a = casc_out;
        endcase
    end

endmodule

// File: rtl/outpin_ctrl.sv
module outpin_ctrl
    import outpin_pkg::*;
#(
    parameter int              C_W   = PORT_REG_W,
    parameter int              R_W   = DIV_REG_W,
    parameter int              A_W   = MODE_REG_W,
    parameter logic [A_W-1:0]  A_RST = MODE_RST
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_en_n,
    input  logic           ref_pulse,
    input  logic           fb_pulse,
    output logic           out_a,
    output logic           out_b_val,
    output logic           out_b_oe,
    output logic [C_W-1:0] cfg_c,
    output logic [R_W-1:0] cfg_r,
    output logic [A_W-1:0] cfg_a
);

    localparam int SH_W  = A_W;
    localparam int CNT_W = $clog2(SH_W + 2);

    logic             sclk_rise_w;
    logic             sclk_fall_w;
    logic             en_rise_w;
    logic             frame_open_w;
    logic [SH_W-1:0]  shift_word_w;
    logic [CNT_W-1:0] bit_cnt_w;
    logic             dout_w;

    ser_edge edge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_en_n   (ser_en_n),
        .sclk_rise  (sclk_rise_w),
        .sclk_fall  (sclk_fall_w),
        .en_rise    (en_rise_w),
        .frame_open (frame_open_w)
    );

    shift_path #(
        .SH_W  (SH_W),
        .CNT_W (CNT_W)
    ) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise_w),
        .sclk_fall  (sclk_fall_w),
        .frame_open (frame_open_w),
        .ser_dat    (ser_dat),
        .shift_word (shift_word_w),
        .bit_cnt    (bit_cnt_w),
        .casc_out   (dout_w)
    );

    cfg_bank #(
        .C_W   (C_W),
        .R_W   (R_W),
        .A_W   (A_W),
        .CNT_W (CNT_W),
        .A_RST (A_RST)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_stb   (en_rise_w),
        .bit_cnt    (bit_cnt_w),
        .shift_word (shift_word_w),
        .cfg_c      (cfg_c),
        .cfg_r      (cfg_r),
        .cfg_a      (cfg_a)
    );

    outa_mux mux_i (
        .sel       (cfg_a[A_W-1:A_W-2]),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .casc_out  (dout_w),
        .port_bit  (cfg_c[PORT_BIT]),
        .out_a     (out_a)
    );

    // Open-drain port: value is always low, enable drops for high impedance.
    assign out_b_val = 1'b0;
    assign out_b_oe  = ~cfg_c[OUTB_BIT];

endmodule

// File: rtl/outpin_ctrl_chk.sv
module outpin_ctrl_chk #(
    parameter int             C_W   = 8,
    parameter int             R_W   = 16,
    parameter int             A_W   = 24,
    parameter logic [A_W-1:0] A_RST = '0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ser_clk,
    input logic           ser_en_n,
    input logic           out_a,
    input logic           out_b_oe,
    input logic           dout,
    input logic [C_W-1:0] cfg_c,
    input logic [R_W-1:0] cfg_r,
    input logic [A_W-1:0] cfg_a
);

    // Cascade bit only moves one cycle after a sampled serial-clock fall.
    assert_casc_fall_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(ser_clk, 2) && !$past(ser_clk)) |-> $stable(dout));

    // Registers only change one cycle after a sampled enable rise.
    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(ser_en_n) && !$past(ser_en_n, 2))
        |-> ($stable(cfg_a) && $stable(cfg_c) && $stable(cfg_r)));

    // Open-drain enable is steered by the port register alone.
    assert_outb_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_c) |-> $stable(out_b_oe));

    // While the cascade source is selected and quiet, out_a is quiet too.
    assert_casc_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_a[A_W-1:A_W-2] == 2'b01 && $stable(cfg_a) && $stable(dout))
        |-> $stable(out_a));

    // Reset leaves the power-on values in place.
    assert_reset_vals_R9: assert property (@(posedge clk)
        !rst_n |=> (out_b_oe && cfg_a == A_RST && cfg_c == '0 && cfg_r == '0 && !dout));

endmodule

bind outpin_ctrl outpin_ctrl_chk #(
    .C_W   (C_W),
    .R_W   (R_W),
    .A_W   (A_W),
    .A_RST (A_RST)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_en_n (ser_en_n),
    .out_a    (out_a),
    .out_b_oe (out_b_oe),
    .dout     (dout_w),
    .cfg_c    (cfg_c),
    .cfg_r    (cfg_r),
    .cfg_a    (cfg_a)
);

// File: tb/outpin_ctrl_tb.sv
module outpin_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_en_n = 1'b1;
    logic        ref_pulse = 1'b0;
    logic        fb_pulse = 1'b0;
    logic        out_a;
    logic        out_b_val;
    logic        out_b_oe;
    logic [7:0]  cfg_c;
    logic [15:0] cfg_r;
    logic [23:0] cfg_a;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    outpin_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_en_n  (ser_en_n),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .out_a     (out_a),
        .out_b_val (out_b_val),
        .out_b_oe  (out_b_oe),
        .cfg_c     (cfg_c),
        .cfg_r     (cfg_r),
        .cfg_a     (cfg_a)
    );

    // len, word, ref, fb, expected out_a, expected out_b_oe
    typedef struct packed {
        logic [4:0]  len;
        logic [23:0] word;
        logic        ref_v;
        logic        fb_v;
        logic        exp_a;
        logic        exp_oe;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{5'd24, 24'h000000, 1'b1, 1'b1, 1'b0, 1'b1},  // port mode, port bit 0
        '{5'd8,  24'h000002, 1'b0, 1'b0, 1'b1, 1'b1},  // port bit 1
        '{5'd8,  24'h000001, 1'b1, 1'b1, 1'b0, 1'b0},  // port bit 0, pin B released
        '{5'd24, 24'hC00000, 1'b1, 1'b0, 1'b1, 1'b0},  // reference pulse
        '{5'd24, 24'hC12345, 1'b0, 1'b1, 1'b0, 1'b0},
        '{5'd24, 24'h800000, 1'b0, 1'b1, 1'b1, 1'b0},  // feedback pulse
        '{5'd24, 24'h8ABCDE, 1'b1, 1'b0, 1'b0, 1'b0},
        '{5'd16, 24'h00BEEF, 1'b0, 1'b1, 1'b1, 1'b0},  // divider reg, select kept
        '{5'd8,  24'h0000A6, 1'b0, 1'b1, 1'b1, 1'b1},  // port reg, pin B driven
        '{5'd24, 24'h400000, 1'b1, 1'b1, 1'b0, 1'b1}   // cascade: last fall carries bit 23
    };

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic sclk_up(input logic b);
        @(negedge clk);
        ser_dat = b;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic sclk_down();
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input logic [31:0] word);
        @(negedge clk);
        ser_en_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            sclk_up(word[i]);
            sclk_down();
        end
        ser_en_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Reset defaults (R9, R8)
        check("R9 cfg_a reset", 32'(cfg_a), 32'h400000);
        check("R9 cfg_c reset", 32'(cfg_c), 32'h0);
        check("R9 cfg_r reset", 32'(cfg_r), 32'h0);
        check("R9 out_a reset (cascade 0)", 32'(out_a), 32'h0);
        check("R9 out_b_oe reset", 32'(out_b_oe), 32'h1);
        check("R8 out_b_val", 32'(out_b_val), 32'h0);

        // Vector table: R1..R4 load, R6 selection, R8 open drain
        for (int v = 0; v < NVEC; v++) begin
            send_frame(int'(VECS[v].len), 32'(VECS[v].word));
            ref_pulse = VECS[v].ref_v;
            fb_pulse  = VECS[v].fb_v;
            @(negedge clk);
            if (VECS[v].len == 5'd8)
                check("R2 R1 cfg_c load", 32'(cfg_c), 32'(VECS[v].word[7:0]));
            else if (VECS[v].len == 5'd16)
                check("R3 R1 cfg_r load", 32'(cfg_r), 32'(VECS[v].word[15:0]));
            else
                check("R4 R1 cfg_a load", 32'(cfg_a), 32'(VECS[v].word));
            check("R6 out_a select", 32'(out_a), 32'(VECS[v].exp_a));
            check("R8 out_b_oe", 32'(out_b_oe), 32'(VECS[v].exp_oe));
        end
        check("R5 cfg_r kept after other frames", 32'(cfg_r), 32'hBEEF);

        // Flip pulse inputs in port mode: no effect on out_a (R6)
        send_frame(24, 32'h000000);
        send_frame(8, 32'h02);
        ref_pulse = 1'b0;
        fb_pulse  = 1'b0;
        @(negedge clk);
        check("R6 port mode ignores pulses", 32'(out_a), 32'h1);

        // Ignored lengths (R5)
        send_frame(12, 32'hFFF);
        check("R5 12-bit cfg_c", 32'(cfg_c), 32'h02);
        check("R5 12-bit cfg_r", 32'(cfg_r), 32'hBEEF);
        check("R5 12-bit cfg_a", 32'(cfg_a), 32'h000000);

        // Reset with pin B released forces it driven again (R9)
        send_frame(8, 32'h01);
        check("R8 out_b released", 32'(out_b_oe), 32'h0);
        do_reset();
        check("R9 out_b_oe after reset", 32'(out_b_oe), 32'h1);
        check("R9 cfg_a after reset", 32'(cfg_a), 32'h400000);

        // Falling-edge cascade timing (R7), 26 bits: 1, 0, then zeros
        @(negedge clk);
        ser_en_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 1; k <= 26; k++) begin
            sclk_up((k == 1) ? 1'b1 : 1'b0);
            if (k == 24) check("R7 before fall 24", 32'(out_a), 32'h0);
            if (k == 25) check("R7 holds across rise 25", 32'(out_a), 32'h1);
            sclk_down();
            if (k == 24) check("R7 after fall 24", 32'(out_a), 32'h1);
            if (k == 25) check("R7 after fall 25", 32'(out_a), 32'h0);
        end
        ser_en_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 26-bit cfg_a", 32'(cfg_a), 32'h400000);
        check("R5 26-bit cfg_c", 32'(cfg_c), 32'h0);
        check("R5 26-bit cfg_r", 32'(cfg_r), 32'h0);

        summary();
        $finish;
    end

endmodule